// File: doc/BRIEF.md
# Buffered SPI Master Datapath

This block is the data path of an SPI master. Software-side logic pushes words through a write port into an 8-entry transmit FIFO. From there each word moves into a staging register, and then into a serializer stage that drives the serial output. While a word is being shifted out, the next word already sits in the staging register. As a result, consecutive words stream with no gap for as long as the FIFO is kept fed. When nothing is left, the transfer ends and chip select is released.

On the receive side, each incoming bit is first caught in a one-bit skew register on the rising serial clock. On the following falling edge it is shifted into a receive shift register. When the programmed word length has been collected, the word is pushed into an 8-entry receive FIFO, which is read through a show-ahead read port.

A 5-bit length field and a bit-order control set the word format. Status outputs report empty, full and sticky overrun for each FIFO. The serial clock is the system clock divided by a fixed 4, in SPI mode 0.

Top module: `spi_stream_master`

## Requirements
- R1: `word_len` sets the bits per word: 0 selects 32 bits and 1..31 select that many. The value is taken at the start of each word and held until the word ends.
- R2: With `lsb_first`=1, bit 0 of a word is sent first and the first received bit lands in bit 0. With `lsb_first`=0, bit n-1 is sent first and the first received bit lands in bit n-1. A received word occupies bits n-1..0 and its upper bits read as zero.
- R3: `sclk` is low whenever `cs_n` is high. Each bit lasts 4 clock cycles, 2 with `sclk` low followed by 2 with `sclk` high. `mosi` does not change while `sclk` is high. `miso` is sampled on the rising edge of `sclk`.
- R4: `tx_empty` is 1 exactly when the transmit FIFO holds no word, and `tx_full` is 1 when it holds 8. A write to an idle block clears `tx_empty` at the next clock edge; one edge later `tx_empty` is 1 again because the word has moved to the staging register. Ten writes on consecutive cycles to an idle block leave `tx_full` at 1: one word is shifting, one is staged and eight are queued.
- R5: A write while `tx_full` is 1 is dropped and never transmitted, and it sets `tx_ovr`. `tx_ovr` stays set until `ovr_clr[0]` is 1 in a cycle with no new overrun.
- R6: While words are available, rising `sclk` edges stay exactly 4 clock cycles apart across word boundaries, and `cs_n` stays low between words.
- R7: When no word is waiting at the end of a word, `cs_n` goes high exactly 4 clock cycles after the final falling `sclk` edge.
- R8: A received word enters the receive FIFO at the same clock edge that produces its final falling `sclk` edge. `rx_empty` is 0 while unread words remain. `rd_data` shows the oldest word, and `rd_en` removes one word.
- R9: `rx_full` is 1 when 8 unread words are held. A word completing while the FIFO is full is dropped and sets `rx_ovr`, which stays set until `ovr_clr[1]` is 1 in a cycle with no new overrun.
- R10: After reset `cs_n`=1, `sclk`=0, `mosi`=0, `tx_empty`=`rx_empty`=1, and `tx_full`, `rx_full`, `tx_ovr` and `rx_ovr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push `wr_data` into the transmit FIFO |
| wr_data | input | 32 | Word to transmit |
| rd_en | input | 1 | Pop the oldest received word |
| rd_data | output | 32 | Oldest unread received word |
| word_len | input | 5 | Bits per word, 0 means 32 |
| lsb_first | input | 1 | 1 selects least-significant-bit-first order |
| ovr_clr | input | 2 | Write-one-to-clear: bit 0 clears `tx_ovr`, bit 1 clears `rx_ovr` |
| tx_empty | output | 1 | Transmit FIFO holds no word |
| tx_full | output | 1 | Transmit FIFO holds 8 words |
| rx_empty | output | 1 | Receive FIFO holds no unread word |
| rx_full | output | 1 | Receive FIFO holds 8 unread words |
| tx_ovr | output | 1 | Sticky: a write was dropped on a full transmit FIFO |
| rx_ovr | output | 1 | Sticky: a received word was dropped on a full receive FIFO |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions check on every cycle the properties that hold locally:
- `sclk` stays low while deselected, and `mosi` holds steady while `sclk` is high.
- The empty and full flags never contradict each other.
- A write into a full FIFO raises `tx_ovr`, and both overrun flags hold until cleared.
- Receive data and the receive full flag persist until a read.

Only the bench's scenarios can show the rest, since each needs a whole transfer:
- that the bits of a word appear in the programmed order and length;
- that words stream with an even bit period;
- that chip select is released exactly four cycles after the last bit;
- that the transmit path holds ten words before the FIFO reports full;
- that the right received words are kept or dropped when the receive FIFO fills.

// File: rtl/spis_pkg.sv
package spis_pkg;
    localparam int DATA_W     = 32;
    localparam int LEN_W      = 5;
    localparam int CNT_W      = LEN_W + 1;
    localparam int FIFO_DEPTH = 8;
    localparam int DIV        = 4;
    localparam int PH_W       = $clog2(DIV);
    localparam int TL_W       = $clog2(DIV + 1);

    typedef enum logic [1:0] {
        LNK_IDLE,
        LNK_SHIFT,
        LNK_TAIL
    } link_state_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             lsb_first;
    } word_fmt_t;

    // number of bits in a word; a zero field means the full data width
    function automatic logic [CNT_W-1:0] eff_len(input logic [LEN_W-1:0] len);
        return (len == '0) ? CNT_W'(DATA_W) : {1'b0, len};
    endfunction

    function automatic logic [DATA_W-1:0] len_mask(input logic [CNT_W-1:0] n);
        return (n >= CNT_W'(DATA_W)) ? '1 : ((DATA_W'(1) << n) - DATA_W'(1));
    endfunction
endpackage

// File: rtl/spis_fifo.sv
module spis_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         push_drop
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign full      = (cnt == FULL_CNT);
    assign empty     = (cnt == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign push_drop = push && full;
    assign dout      = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + (AW + 1)'(do_push) - (AW + 1)'(do_pop);
        end
    end
endmodule

// File: rtl/spis_link.sv
module spis_link
    import spis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stage_valid,
    input  logic [DATA_W-1:0] stage_word,
    input  word_fmt_t         fmt_in,
    output logic              stage_take,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              rise_stb,
    output logic              fall_stb,
    output logic              last_stb,
    output word_fmt_t         fmt_cur
);
    link_state_t       st;
    logic [PH_W-1:0]   ph;
    logic [LEN_W-1:0]  idx;
    logic [DATA_W-1:0] cur;
    word_fmt_t         fmt_q;
    logic [TL_W-1:0]   tail;
    logic [CNT_W-1:0]  nbits, bit_sel;
    logic              shifting, start;

    assign nbits    = eff_len(fmt_q.len);
    assign shifting = (st == LNK_SHIFT);
    assign rise_stb = shifting && (ph == PH_W'(DIV / 2 - 1));
    assign fall_stb = shifting && (ph == PH_W'(DIV - 1));
    assign last_stb = fall_stb && ({1'b0, idx} == nbits - CNT_W'(1));
    assign start    = stage_valid && !shifting;
    assign stage_take = start || (last_stb && stage_valid);

    assign bit_sel  = fmt_q.lsb_first ? {1'b0, idx}
                                      : (nbits - CNT_W'(1) - {1'b0, idx});
    assign sclk     = shifting && (ph >= PH_W'(DIV / 2));
    assign mosi     = shifting && cur[bit_sel[LEN_W-1:0]];
    assign cs_n     = (st == LNK_IDLE);
    assign fmt_cur  = fmt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= LNK_IDLE;
            ph    <= '0;
            idx   <= '0;
            cur   <= '0;
            fmt_q <= '0;
            tail  <= '0;
        end else if (start) begin
            st    <= LNK_SHIFT;
            ph    <= '0;
            idx   <= '0;
            cur   <= stage_word;
            fmt_q <= fmt_in;
        end else begin
            case (st)
                LNK_SHIFT: begin
                    ph <= fall_stb ? '0 : ph + 1'b1;
                    if (fall_stb) begin
                        if (last_stb) begin
                            idx <= '0;
                            if (stage_valid) begin
                                cur   <= stage_word;
                                fmt_q <= fmt_in;
                            end else begin
                                st   <= LNK_TAIL;
                                tail <= TL_W'(DIV);
                            end
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                LNK_TAIL: begin
                    tail <= tail - 1'b1;
                    if (tail == TL_W'(1)) st <= LNK_IDLE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spis_rx.sv
module spis_rx
    import spis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              miso,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              last_stb,
    input  word_fmt_t         fmt,
    output logic              push,
    output logic [DATA_W-1:0] word
);
    logic              skew;
    logic [DATA_W-1:0] acc, nxt;
    logic [CNT_W-1:0]  nbits;

    assign nbits = eff_len(fmt.len);
    assign nxt   = fmt.lsb_first ? {skew, acc[DATA_W-1:1]}
                                 : {acc[DATA_W-2:0], skew};
    assign word  = fmt.lsb_first ? (nxt >> (CNT_W'(DATA_W) - nbits))
                                 : (nxt & len_mask(nbits));
    assign push  = last_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            skew <= 1'b0;
            acc  <= '0;
        end else begin
            if (rise_stb) skew <= miso;
            if (fall_stb) acc <= last_stb ? '0 : nxt;
        end
    end
endmodule

// File: rtl/spi_stream_master.sv
module spi_stream_master
    import spis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [LEN_W-1:0]  word_len,
    input  logic              lsb_first,
    input  logic [1:0]        ovr_clr,
    output logic              tx_empty,
    output logic              tx_full,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              tx_ovr,
    output logic              rx_ovr,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    word_fmt_t         fmt_in, fmt_cur;
    logic [DATA_W-1:0] tx_head, stg_word, rx_word;
    logic              stg_valid, stage_take, tx_pop, tx_drop;
    logic              rise_stb, fall_stb, last_stb, rx_push, rx_drop;

    assign fmt_in = '{len: word_len, lsb_first: lsb_first};
    assign tx_pop = !tx_empty && (!stg_valid || stage_take);

    spis_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(wr_en), .din(wr_data), .pop(tx_pop),
        .dout(tx_head), .empty(tx_empty), .full(tx_full), .push_drop(tx_drop)
    );

    // staging register between the transmit FIFO and the serializer
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_valid <= 1'b0;
            stg_word  <= '0;
        end else if (tx_pop) begin
            stg_valid <= 1'b1;
            stg_word  <= tx_head;
        end else if (stage_take) begin
            stg_valid <= 1'b0;
        end
    end

    spis_link u_link (
        .clk(clk), .rst(rst), .stage_valid(stg_valid), .stage_word(stg_word),
        .fmt_in(fmt_in), .stage_take(stage_take), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .last_stb(last_stb), .fmt_cur(fmt_cur)
    );

    spis_rx u_rx (
        .clk(clk), .rst(rst), .miso(miso), .rise_stb(rise_stb),
        .fall_stb(fall_stb), .last_stb(last_stb), .fmt(fmt_cur),
        .push(rx_push), .word(rx_word)
    );

    spis_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_word), .pop(rd_en),
        .dout(rd_data), .empty(rx_empty), .full(rx_full), .push_drop(rx_drop)
    );

    // sticky overrun flags, a new overrun wins over a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ovr <= 1'b0;
            rx_ovr <= 1'b0;
        end else begin
            tx_ovr <= tx_drop || (tx_ovr && !ovr_clr[0]);
            rx_ovr <= rx_drop || (rx_ovr && !ovr_clr[1]);
        end
    end
endmodule

// File: rtl/spis_checker.sv
module spis_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] ovr_clr,
    input logic       tx_empty,
    input logic       tx_full,
    input logic       rx_empty,
    input logic       rx_full,
    input logic       tx_ovr,
    input logic       rx_ovr,
    input logic       sclk,
    input logic       mosi,
    input logic       cs_n
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk); // R3
    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (rst) (sclk && $past(sclk)) |-> $stable(mosi)); // R3
    AST_TX_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) !(tx_full && tx_empty)); // R4
    AST_TX_OVR_SET: assert property (@(posedge clk) disable iff (rst) (wr_en && tx_full) |=> tx_ovr); // R5
    AST_TX_OVR_STICKY: assert property (@(posedge clk) disable iff (rst) (tx_ovr && !ovr_clr[0]) |=> tx_ovr); // R5
    AST_RX_DATA_KEPT: assert property (@(posedge clk) disable iff (rst) (!rx_empty && !rd_en) |=> !rx_empty); // R8
    AST_RX_FULL_KEPT: assert property (@(posedge clk) disable iff (rst) (rx_full && !rd_en) |=> rx_full); // R9
    AST_RX_OVR_STICKY: assert property (@(posedge clk) disable iff (rst) (rx_ovr && !ovr_clr[1]) |=> rx_ovr); // R9
    AST_RX_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) !(rx_full && rx_empty)); // R9
endmodule

bind spi_stream_master spis_checker u_chk (.*);

// File: tb/tb_spi_stream_master.sv
`timescale 1ns/1ps
module tb_spi_stream_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, lsb_first = 1'b0, miso = 1'b0;
    logic [31:0] wr_data = '0;
    logic [4:0]  word_len = '0;
    logic [1:0]  ovr_clr = '0;
    logic [31:0] rd_data;
    logic        tx_empty, tx_full, rx_empty, rx_full, tx_ovr, rx_ovr, sclk, mosi, cs_n;

    always #4 clk = ~clk;

    spi_stream_master dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .word_len(word_len), .lsb_first(lsb_first),
        .ovr_clr(ovr_clr), .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_empty(rx_empty), .rx_full(rx_full), .tx_ovr(tx_ovr), .rx_ovr(rx_ovr),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic        m_txovr = 0, m_rxovr = 0;
    logic        r_wr = 0, r_txfull = 0, r_rd = 0;
    logic [31:0] r_wdata = '0;
    logic [1:0]  r_clr = '0;
    logic        ps = 0, pcs = 1, pmosi = 0, model_on = 0, loaded = 0;
    int          n = 0, sbit = 0, last_rise = -1, last_fall = -1000, slave_cnt = 0;
    logic [31:0] out_w = '0, in_w = '0, push_val = '0, expw = '0;
    logic        rose, fell, push_evt, full_pre;

    function automatic int nb();
        return (word_len == 5'd0) ? 32 : int'(word_len);
    endfunction
    function automatic logic [31:0] msk(int k);
        return (k >= 32) ? 32'hFFFF_FFFF : ((32'd1 << k) - 32'd1);
    endfunction
    function automatic int pos(int k);
        return lsb_first ? k : nb() - 1 - k;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // cycle-by-cycle model and serial slave, sampled on the falling clock
    always @(negedge clk) begin
        if (model_on && !done) begin
            n++;
            if (n > 150000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", n, 150000);
                finish_run();
            end
            // effects of the last rising clock edge
            if (r_wr && !r_txfull) txq.push_back(r_wdata);
            if (r_wr && r_txfull) m_txovr = 1;
            else if (r_clr[0]) m_txovr = 0;
            full_pre = (rxq.size() == 8);
            if (r_rd && rxq.size() > 0) void'(rxq.pop_front());

            rose = sclk && !ps;
            fell = !sclk && ps;
            push_evt = 0;
            chk(!(cs_n && sclk), "R3 sclk low while deselected", {31'd0, sclk}, 32'd0);
            if (sclk && ps)
                chk(mosi == pmosi, "R3 mosi held while sclk high", {31'd0, mosi}, {31'd0, pmosi});
            if (rose) begin
                if (last_rise >= 0)
                    chk(n - last_rise == 4, "R6 rising edges 4 cycles apart", n - last_rise, 4);
                last_rise = n;
                in_w[pos(sbit)] = mosi;
                sbit++;
            end
            if (fell && sbit == nb()) begin
                if (txq.size() > 0) expw = txq.pop_front() & msk(nb());
                else expw = 32'hDEAD_BEEF;
                chk(in_w == expw, "R1 R2 transmitted word", in_w, expw);
                push_evt = 1;
                push_val = out_w & msk(nb());
                sbit = 0;
                loaded = 0;
                in_w = '0;
                last_fall = n;
            end
            if (cs_n && !pcs)
                chk(n - last_fall == 4, "R7 chip select release delay", n - last_fall, 4);
            if (cs_n) begin
                sbit = 0;
                loaded = 0;
                last_rise = -1;
                in_w = '0;
            end
            if (!cs_n && !loaded) begin
                slave_cnt++;
                out_w = 32'h9E37_79B9 * slave_cnt + 32'h1234_5677;
                loaded = 1;
                miso = out_w[pos(0)];
            end else if (fell && loaded) begin
                miso = out_w[pos(sbit)];
            end

            if (push_evt && full_pre) m_rxovr = 1;
            else if (r_clr[1]) m_rxovr = 0;
            if (push_evt && !full_pre) rxq.push_back(push_val);

            chk(rx_empty == (rxq.size() == 0), "R8 rx_empty", {31'd0, rx_empty}, {31'd0, rxq.size() == 0});
            chk(rx_full == (rxq.size() == 8), "R9 rx_full", {31'd0, rx_full}, {31'd0, rxq.size() == 8});
            if (rxq.size() > 0) chk(rd_data == rxq[0], "R8 rd_data oldest word", rd_data, rxq[0]);
            chk(rx_ovr == m_rxovr, "R9 rx_ovr", {31'd0, rx_ovr}, {31'd0, m_rxovr});
            chk(tx_ovr == m_txovr, "R5 tx_ovr", {31'd0, tx_ovr}, {31'd0, m_txovr});

            r_wr = wr_en; r_txfull = tx_full; r_wdata = wr_data;
            r_rd = rd_en; r_clr = ovr_clr;
            ps = sclk; pcs = cs_n; pmosi = mosi;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_burst(int cnt, logic [31:0] seed);
        for (int i = 0; i < cnt; i++) begin
            wr_en = 1;
            wr_data = seed + 32'h0F1E_2D3C * i;
            step();
        end
        wr_en = 0;
    endtask

    task automatic wait_idle();
        repeat (4) step();
        while (!cs_n || !tx_empty) step();
        repeat (3) step();
    endtask

    task automatic read_all();
        while (!rx_empty) begin
            rd_en = 1;
            step();
        end
        rd_en = 0;
        step();
    endtask

    initial begin
        repeat (4) step();
        rst = 0;
        model_on = 1;
        @(negedge clk);
        chk(cs_n == 1 && sclk == 0 && mosi == 0, "R10 serial pins after reset", {29'd0, cs_n, sclk, mosi}, 32'd4);
        chk(tx_empty && rx_empty && !tx_full && !rx_full, "R10 fifo flags after reset",
            {28'd0, tx_empty, rx_empty, tx_full, rx_full}, 32'hC);
        chk(!tx_ovr && !rx_ovr, "R10 overrun flags after reset", {30'd0, tx_ovr, rx_ovr}, 32'd0);
        @(posedge clk); #1;

        // 32-bit words, MSB first: single write shows the staging move
        word_len = 5'd0; lsb_first = 0;
        wr_en = 1; wr_data = 32'hC3A5_0F1E;
        @(posedge clk); #1 wr_en = 0;
        @(negedge clk);
        chk(tx_empty == 0, "R4 tx_empty clears after write", {31'd0, tx_empty}, 32'd0);
        @(negedge clk);
        chk(tx_empty == 1, "R4 word moved to staging register", {31'd0, tx_empty}, 32'd1);
        @(posedge clk); #1;
        wait_idle();
        write_burst(3, 32'h8000_0001);
        wait_idle();
        read_all();

        // 8-bit words, LSB first
        word_len = 5'd8; lsb_first = 1;
        write_burst(4, 32'h0000_00B1);
        wait_idle();
        read_all();

        // 5-bit words, MSB first
        word_len = 5'd5; lsb_first = 0;
        write_burst(2, 32'h0000_0013);
        wait_idle();
        read_all();

        // 1-bit words, LSB first
        word_len = 5'd1; lsb_first = 1;
        write_burst(3, 32'h0000_0001);
        wait_idle();
        read_all();

        // fill both FIFOs with 32-bit MSB-first words
        word_len = 5'd0; lsb_first = 0;
        write_burst(10, 32'h5A5A_0000);
        chk(tx_full == 1, "R4 ten writes fill the transmit FIFO", {31'd0, tx_full}, 32'd1);
        write_burst(1, 32'hFFFF_0BAD);
        chk(tx_ovr == 1, "R5 write on full sets tx_ovr", {31'd0, tx_ovr}, 32'd1);
        ovr_clr = 2'b01; step(); ovr_clr = 2'b00;
        chk(tx_ovr == 0, "R5 tx_ovr cleared by write of one", {31'd0, tx_ovr}, 32'd0);
        wait_idle();
        chk(rx_full == 1, "R9 eight unread words set rx_full", {31'd0, rx_full}, 32'd1);
        chk(rx_ovr == 1, "R9 dropped words set rx_ovr", {31'd0, rx_ovr}, 32'd1);
        read_all();
        ovr_clr = 2'b10; step(); ovr_clr = 2'b00;
        chk(rx_ovr == 0, "R9 rx_ovr cleared by write of one", {31'd0, rx_ovr}, 32'd0);
        chk(txq.size() == 0, "R5 dropped word never sent", txq.size(), 32'd0);
        repeat (4) step();
        finish_run();
    end
endmodule